// File: doc/BRIEF.md
# Scalar Out-of-Order Issue Scoreboard

This block sits behind a decoder and decides, one clock at a time, which waiting instruction starts execution. Instructions come in program order as an opcode, a destination register and up to two sources, where the second source can be replaced by an immediate. Each one is held in a small window of waiting entries. The oldest entry whose operands and destination are free is sent to a shared, pipelined execute path. Simple integer operations need one execute cycle and a load needs five. An instruction that depends on an unfinished result waits in the window, and younger instructions with no such conflict start ahead of it.

A busy flag per architectural register is set when the writer starts execute and cleared in its write-back cycle. The clear is bypassed to the issue check, so a consumer starts execute in the same clock as its producer's write back. That is the clock right after the producer's last execute cycle. Only one result is written back per clock, and the oldest finished entry goes first. The block numbers every accepted instruction, reports start-of-execute and write-back events by number, and exposes a cycle counter. A bench can stamp each instruction's stage entry cycles from these and compare them with a timing table.

Top module: `sb_ooo_scoreboard`

## Requirements
- R1: After a synchronous active-high reset the window is empty, `in_ready` is 1, `issue_valid` and `wb_valid` are 0, `cycle_now` is 0 and the next accepted instruction gets tag 0.
- R2: Accepted instructions (`in_valid` and `in_ready` both high at a clock edge) receive consecutive tags 0, 1, 2, ... modulo 16, shown on `accept_tag` in the cycle they are presented.
- R3: An instruction accepted in cycle a with no conflict starts execute in cycle a+1. An opcode other than 5 writes back exactly one cycle after it starts execute, if no older result competes.
- R4: Opcode 5 (LOAD, 0=ADD, 1=SUB, 2=AND, 3=OR, 4=SRL) writes back five cycles after it starts execute.
- R5: A source register (the second source only when `in_use2` is 1) written by an unfinished older instruction holds the consumer. The consumer starts execute in the producer's write-back cycle at the earliest, and in exactly that cycle when nothing else blocks it.
- R6: While an older instruction is held, a younger instruction with no conflict starts execute ahead of it.
- R7: A younger instruction is held if it writes a register that an older unfinished instruction writes, or that an older not-yet-started instruction reads. It starts no earlier than the cycle after that reader starts.
- R8: At most one instruction starts execute per cycle, and the oldest ready one is chosen.
- R9: At most one write back happens per cycle. When two finished results compete, the older one writes back first and the other one follows in the next cycle.
- R10: The window holds 4 entries. `in_ready` is 0 while it is full, and an instruction offered then is not accepted and uses no tag.
- R11: When `in_use2` is 0 the second source field creates no dependence.
- R12: `cycle_now` increases by one every clock after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_op | input | 3 | Opcode, 5 = LOAD, 0 to 4 are one-cycle operations |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source (address register for LOAD) |
| in_src2 | input | 3 | Second source register |
| in_use2 | input | 1 | 1: second source is a register, 0: immediate |
| in_ready | output | 1 | Window has a free entry |
| accept_tag | output | 4 | Tag the offered instruction gets if accepted |
| issue_valid | output | 1 | An instruction starts execute this cycle |
| issue_tag | output | 4 | Tag of that instruction |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_tag | output | 4 | Tag of that result |
| cycle_now | output | 16 | Cycle counter for stage stamps |

## Verification
A sweep pairs a producer of each latency class with a consumer of each latency class under five operand relations. The relations are none, first-source match, second-source match as a register, second-source match as an immediate, and matching destinations. The sweep tells true dependences apart from field values that only look like them, and checks the one-cycle and five-cycle countdowns. A mixed program with a load-blocked consumer and independent followers separates out-of-order start from in-order stall. It also fills the window and has a later consumer wait on a producer that has not yet started. Two short programs cover the rest: one makes two results finish in the same cycle, and one makes a writer wait behind an older reader.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NREG  = 8;
    localparam int RW    = $clog2(NREG);
    localparam int TAG_W = 4;
    localparam int CNT_W = 4;
    localparam logic [2:0] OP_LOAD = 3'd5;

    typedef enum logic [1:0] {ST_WAIT, ST_EXEC, ST_DONE} st_e;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [RW-1:0]     dst;
        logic [RW-1:0]     s1;
        logic [RW-1:0]     s2;
        logic              use2;
        logic              ld;
        st_e               st;
        logic [CNT_W-1:0]  cnt;
    } ent_t;
endpackage

// File: rtl/sb_pick.sv
module sb_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest index is the oldest entry and wins
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard
    import sb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  ent_t [DEPTH-1:0] win,
    input  logic [NREG-1:0]  busy_eff,
    output logic [DEPTH-1:0] ready
);
    for (genvar j = 0; j < DEPTH; j++) begin : g_ent
        logic rdy;
        always_comb begin
            logic blk;
            // conflicts with instructions already in execute or awaiting write back
            blk = busy_eff[win[j].s1] | (win[j].use2 & busy_eff[win[j].s2])
                | busy_eff[win[j].dst];
            // conflicts with older entries that have not started yet
            for (int i = 0; i < j; i++) begin
                if (win[i].vld && win[i].st == ST_WAIT) begin
                    if (win[i].dst == win[j].s1
                        || (win[j].use2 && win[i].dst == win[j].s2)
                        || win[i].dst == win[j].dst
                        || win[i].s1 == win[j].dst
                        || (win[i].use2 && win[i].s2 == win[j].dst))
                        blk = 1'b1;
                end
            end
            rdy = win[j].vld && (win[j].st == ST_WAIT) && !blk;
        end
        assign ready[j] = rdy;
    end
endmodule

// File: rtl/sb_ooo_scoreboard.sv
module sb_ooo_scoreboard
    import sb_pkg::*;
#(
    parameter int DEPTH    = 4,
    parameter int LOAD_LAT = 5,
    parameter int CYC_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       in_op,
    input  logic [RW-1:0]    in_dst,
    input  logic [RW-1:0]    in_src1,
    input  logic [RW-1:0]    in_src2,
    input  logic             in_use2,
    output logic             in_ready,
    output logic [TAG_W-1:0] accept_tag,
    output logic             issue_valid,
    output logic [TAG_W-1:0] issue_tag,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic [CYC_W-1:0] cycle_now
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] LD_CNT = CNT_W'(LOAD_LAT - 1);

    typedef struct packed {
        ent_t [DEPTH-1:0]  win;
        logic [NREG-1:0]   busy;
        logic [TAG_W-1:0]  tag;
        logic [CYC_W-1:0]  cyc;
    } state_t;

    state_t s_q, s_d;

    logic [DEPTH-1:0] done_req, rdy;
    logic [NREG-1:0]  clr_mask, busy_eff;
    logic             wb_vld, iss_vld;
    logic [IDX_W-1:0] wb_idx, iss_idx;
    logic [NREG-1:0]  busy_now;
    logic [RW-1:0]    iss_dst;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            done_req[i] = s_q.win[i].vld && (s_q.win[i].st == ST_DONE);
        end
    end

    sb_pick #(.N(DEPTH), .IW(IDX_W)) u_wb_pick (.req(done_req), .any(wb_vld), .idx(wb_idx));

    always_comb begin
        clr_mask = '0;
        if (wb_vld) clr_mask[s_q.win[wb_idx].dst] = 1'b1;
        busy_eff = s_q.busy & ~clr_mask;
    end

    sb_hazard #(.DEPTH(DEPTH)) u_haz (.win(s_q.win), .busy_eff(busy_eff), .ready(rdy));

    sb_pick #(.N(DEPTH), .IW(IDX_W)) u_iss_pick (.req(rdy), .any(iss_vld), .idx(iss_idx));

    always_comb begin
        ent_t [DEPTH-1:0] w;
        ent_t [DEPTH-1:0] nxt;
        logic [NREG-1:0]  set_mask;
        int               k;

        s_d     = s_q;
        s_d.cyc = s_q.cyc + 1'b1;
        w       = s_q.win;

        // execute countdown and start of execute
        for (int i = 0; i < DEPTH; i++) begin
            if (w[i].vld && w[i].st == ST_EXEC) begin
                w[i].cnt = w[i].cnt - 1'b1;
                if (w[i].cnt == '0) w[i].st = ST_DONE;
            end
            if (iss_vld && IDX_W'(i) == iss_idx) begin
                if (w[i].ld && LD_CNT != '0) begin
                    w[i].st  = ST_EXEC;
                    w[i].cnt = LD_CNT;
                end else begin
                    w[i].st  = ST_DONE;
                    w[i].cnt = '0;
                end
            end
        end

        set_mask = '0;
        if (iss_vld) set_mask[s_q.win[iss_idx].dst] = 1'b1;
        s_d.busy = busy_eff | set_mask;

        // drop the written-back entry, keep age order, append the new one
        nxt = '0;
        k   = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (w[i].vld && !(wb_vld && IDX_W'(i) == wb_idx)) begin
                nxt[k] = w[i];
                k      = k + 1;
            end
        end
        if (in_valid && in_ready && k < DEPTH) begin
            nxt[k].vld  = 1'b1;
            nxt[k].tag  = s_q.tag;
            nxt[k].dst  = in_dst;
            nxt[k].s1   = in_src1;
            nxt[k].s2   = in_src2;
            nxt[k].use2 = in_use2 && (in_op != OP_LOAD);
            nxt[k].ld   = (in_op == OP_LOAD);
            nxt[k].st   = ST_WAIT;
            nxt[k].cnt  = '0;
            s_d.tag     = s_q.tag + 1'b1;
        end
        s_d.win = nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign in_ready    = !s_q.win[DEPTH-1].vld;
    assign accept_tag  = s_q.tag;
    assign issue_valid = iss_vld;
    assign issue_tag   = s_q.win[iss_idx].tag;
    assign wb_valid    = wb_vld;
    assign wb_tag      = s_q.win[wb_idx].tag;
    assign cycle_now   = s_q.cyc;
    assign busy_now    = s_q.busy;
    assign iss_dst     = s_q.win[iss_idx].dst;
endmodule

// File: rtl/sb_ooo_checker.sv
module sb_ooo_checker
    import sb_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic [TAG_W-1:0] accept_tag,
    input logic             issue_valid,
    input logic [TAG_W-1:0] issue_tag,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic [CYC_W-1:0] cycle_now,
    input logic [NREG-1:0]  busy_now,
    input logic [RW-1:0]    iss_dst
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !issue_valid && !wb_valid && cycle_now == '0 && accept_tag == '0));

    assert_tag_step_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (accept_tag == TAG_W'($past(accept_tag) + 1'b1)));

    assert_busy_on_issue_R5: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> busy_now[$past(iss_dst)]);

    assert_issue_not_wb_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && wb_valid) |-> (issue_tag != wb_tag));

    assert_wb_once_R9: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !(wb_valid && wb_tag == $past(wb_tag)));

    assert_full_no_tag_R10: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (accept_tag == $past(accept_tag)));

    assert_cycle_step_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (cycle_now == CYC_W'($past(cycle_now) + 1'b1)));
endmodule

bind sb_ooo_scoreboard sb_ooo_checker #(.CYC_W(CYC_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .accept_tag(accept_tag), .issue_valid(issue_valid), .issue_tag(issue_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .cycle_now(cycle_now),
    .busy_now(busy_now), .iss_dst(iss_dst)
);

// File: tb/sim_sb_ooo_scoreboard.sv
module sim_sb_ooo_scoreboard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic [2:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic        in_use2 = 1'b0;
    logic        in_ready;
    logic [3:0]  accept_tag, issue_tag, wb_tag;
    logic        issue_valid, wb_valid;
    logic [15:0] cycle_now;

    int nchk = 0, nfail = 0;
    int iss_c[16];
    int wb_c[16];

    localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, AND_ = 3'd2, OR_ = 3'd3, LOAD = 3'd5;

    always #10 clk = ~clk;

    sb_ooo_scoreboard u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
        .in_src1(in_src1), .in_src2(in_src2), .in_use2(in_use2), .in_ready(in_ready),
        .accept_tag(accept_tag), .issue_valid(issue_valid), .issue_tag(issue_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .cycle_now(cycle_now)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (issue_valid) iss_c[issue_tag] = int'(cycle_now);
            if (wb_valid)    wb_c[wb_tag]     = int'(cycle_now);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        for (int i = 0; i < 16; i++) begin
            iss_c[i] = -1;
            wb_c[i]  = -1;
        end
        idle(2);
        rst = 1'b0;
    endtask

    // called at a negedge; returns at a negedge after acceptance
    task automatic send(input logic [2:0] op, input logic [2:0] rd, input logic [2:0] ra,
                        input logic [2:0] rb, input logic u2, output int acc, output int tg);
        in_op = op; in_dst = rd; in_src1 = ra; in_src2 = rb; in_use2 = u2;
        in_valid = 1'b1;
        acc = -1; tg = -1;
        while (acc < 0) begin
            if (in_ready) begin
                acc = int'(cycle_now);
                tg  = int'(accept_tag);
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int a, t, a1, t1, a2, t2, a3, t3, a4, t4;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 issue_valid", int'(issue_valid), 0);
        chk("R1 wb_valid", int'(wb_valid), 0);
        chk("R1 cycle_now", int'(cycle_now), 0);
        chk("R1 accept_tag", int'(accept_tag), 0);
        idle(5);
        chk("R12 cycle count", int'(cycle_now), 5);

        // Sweep: producer class x consumer class x operand relation (R3 R4 R5 R11)
        for (int pi = 0; pi < 2; pi++) begin
            for (int ci = 0; ci < 2; ci++) begin
                for (int rel = 0; rel < 5; rel++) begin
                    logic [2:0] pop, cop, crd, cra, crb;
                    logic       cu2;
                    bit         dep;
                    int         lp, lc, exp_i, exp_p;
                    pop = (pi == 0) ? ADD : LOAD;
                    cop = (ci == 0) ? SUB : LOAD;
                    lp  = (pi == 0) ? 1 : 5;
                    lc  = (ci == 0) ? 1 : 5;
                    crd = (rel == 4) ? 3'd6 : 3'd3;
                    cra = (rel == 1) ? 3'd6 : 3'd4;
                    crb = (rel == 2 || rel == 3) ? 3'd6 : 3'd5;
                    cu2 = (ci == 0) && (rel != 3);
                    dep = (rel == 1) || (rel == 2 && cu2) || (rel == 4);
                    do_reset();
                    send(pop, 3'd6, 3'd1, 3'd2, (pi == 0), a, t);
                    send(cop, crd, cra, crb, cu2, a1, t1);
                    idle(14);
                    exp_p = a + 1 + lp;
                    exp_i = a + 2;
                    if (dep && exp_p > exp_i) exp_i = exp_p;
                    chk(pi == 0 ? "R3 producer wb" : "R4 producer wb", wb_c[t], exp_p);
                    chk(dep ? "R5 consumer issue" : "R11 consumer issue", iss_c[t1], exp_i);
                    chk(ci == 0 ? "R3 consumer wb" : "R4 consumer wb", wb_c[t1], exp_i + lc);
                end
            end
        end

        // Mixed program: load-blocked consumer, independent followers, full window
        do_reset();
        send(LOAD, 3'd6, 3'd3, 3'd0, 1'b0, a, t);
        chk("R2 first tag", t, 0);
        send(ADD, 3'd1, 3'd6, 3'd7, 1'b1, a1, t1);
        send(SUB, 3'd2, 3'd4, 3'd5, 1'b1, a2, t2);
        send(OR_, 3'd0, 3'd4, 3'd5, 1'b1, a3, t3);
        chk("R2 tag order", t3, 3);
        chk("R10 in_ready when full", int'(in_ready), 0);
        send(AND_, 3'd3, 3'd1, 3'd4, 1'b1, a4, t4);
        chk("R10 accept after space", a4, a + 5);
        chk("R10 no tag used while full", t4, 4);
        idle(12);
        chk("R4 load wb", wb_c[t], a + 6);
        chk("R6 independent passes", iss_c[t2], a + 3);
        chk("R8 next oldest ready", iss_c[t3], a + 4);
        chk("R5 held consumer issue", iss_c[t1], a + 6);
        chk("R5 held consumer wb", wb_c[t1], a + 7);
        chk("R5 wait on unstarted producer", iss_c[t4], a + 7);
        chk("R3 late wb", wb_c[t4], a + 8);

        // Write-back conflict: load and one-cycle op finish together
        do_reset();
        send(LOAD, 3'd1, 3'd0, 3'd0, 1'b0, a, t);
        idle(3);
        send(SUB, 3'd2, 3'd3, 3'd4, 1'b1, a1, t1);
        idle(10);
        chk("R9 sub issue", iss_c[t1], a + 5);
        chk("R9 older wins", wb_c[t], a + 6);
        chk("R9 younger next", wb_c[t1], a + 7);

        // Write-after-read: writer waits behind older held reader
        do_reset();
        send(LOAD, 3'd6, 3'd0, 3'd0, 1'b0, a, t);
        send(ADD, 3'd1, 3'd6, 3'd2, 1'b1, a1, t1);
        send(SUB, 3'd2, 3'd3, 3'd4, 1'b1, a2, t2);
        idle(12);
        chk("R7 reader issue", iss_c[t1], a + 6);
        chk("R7 writer after reader", iss_c[t2], a + 7);
        chk("R7 writer wb", wb_c[t2], a + 8);

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule